// File: doc/BRIEF.md
# Time-Interleaved Cascaded MAC Array

This block is the multiply-accumulate core of a convolution engine. It has `I` input lanes and `O` output lanes. Each input lane carries one input channel, and each output lane serves four output channels. Every accepted input vector of `I` signed elements goes to all output lanes at once. Within each output lane, the per-lane products are summed through a registered chain of adders rather than an adder tree. The operands entering that chain are skewed one cycle per lane, so stage `i` adds its own product to the registered partial sum of stage `i-1`.

Each output lane serves its four output channels in a time-interleaved way. The block keeps an accepted input vector for four consecutive issue cycles, called slots 0 to 3. In every slot it fetches a new set of weights. The weight address is therefore formed from a term counter, which advances once per vector, and the slot number, which advances every cycle. Each slot has its own 48-bit accumulator in every output lane. A start flag on a vector clears those accumulators, and an end flag presents the four finished dot products on four consecutive cycles. Output channel `4*o + s` corresponds to output lane `o` in slot `s`.

Top module: `cascaded_mac_array`

## Requirements
- R1: After reset, `res_valid` is 0 and `vec_ready` is 1.
- R2: Once a vector is accepted (`vec_valid` and `vec_ready` both 1 at a rising edge), `vec_ready` is 0 for the next three cycles and 1 in the fourth. Vectors can therefore be accepted back to back, one every four cycles.
- R3: During the four issue cycles of a vector, `wt_addr[1:0]` steps through 0, 1, 2, 3, one step per cycle. `wt_addr[AW-1:2]` holds the term index. The term index is 0 for a vector accepted with `vec_first`=1 and grows by one for each later vector. Weight data must be valid on `wt_data` in the same cycle as the address.
- R4: Output lane `o` in slot `s` produces the signed sum, over all vectors from the start vector to the end vector and over all input lanes `i`, of `vec_data[i]` times the weight returned at that vector's slot-`s` address in field `o*I+i` of `wt_data`. Fields are `DW` bits wide, and field `n` starts at bit `n*DW`.
- R5: A vector accepted with `vec_first`=1 discards anything accumulated earlier, including partial sums from vectors that never had an end flag.
- R6: A vector accepted with `vec_last`=1 makes `res_valid` high for exactly four consecutive cycles, with `res_slot` equal to 0, 1, 2, 3 in turn. Vectors without `vec_last` never raise `res_valid`.
- R7: The result for slot `s` appears `I+1+s` rising edges after the edge that accepted the end vector. In that cycle, `res_data[o*48 +: 48]` holds output lane `o`'s result.
- R8: Products and sums are signed and full width. Sums of products of the extreme 16-bit values over many terms come out exact in 48 bits.
- R9: Idle cycles between vectors do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | Input vector offered |
| vec_first | input | 1 | Vector is the first term of a dot product |
| vec_last | input | 1 | Vector is the last term of a dot product |
| vec_data | input | I*DW | One signed operand per input lane |
| vec_ready | output | 1 | Block can accept a vector this cycle |
| wt_addr | output | TERM_W+2 | Weight read address: {term, slot} |
| wt_data | input | O*I*DW | Weights for the current address, one per output/input lane pair |
| res_valid | output | 1 | Finished dot products on res_data |
| res_slot | output | 2 | Interleave slot of the presented results |
| res_data | output | O*ACC_W | One accumulated result per output lane |

## Verification
The assertions assume that `vec_valid` is raised only while `vec_ready` is high. They also assume that the weight storage answers within the same cycle as `wt_addr`. The stimulus honours both conditions: every vector is offered only after `vec_ready` is sampled high, and the bench's weight model is a combinational function of `wt_addr`. Each dot product starts with a `vec_first` vector, and the stimulus keeps term counts well below the accumulator's no-overflow limit, so the expected sums computed in 64-bit arithmetic apply directly.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
    localparam int SLOTS  = 4;
    localparam int SLOT_W = 2;

    typedef struct packed {
        logic              valid;
        logic              first;
        logic              last;
        logic [SLOT_W-1:0] slot;
    } cmac_meta_t;
endpackage

// File: rtl/cmac_issue.sv
module cmac_issue
    import cmac_pkg::*;
#(
    parameter int I      = 4,
    parameter int DW     = 16,
    parameter int TERM_W = 11,
    localparam int AW    = TERM_W + SLOT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vec_valid,
    input  logic            vec_first,
    input  logic            vec_last,
    input  logic [I*DW-1:0] vec_data,
    output logic            vec_ready,
    output logic [I*DW-1:0] issue_data,
    output cmac_meta_t      issue_meta,
    output logic [AW-1:0]   wt_addr
);
    typedef struct packed {
        logic              busy;
        logic [SLOT_W-1:0] slot;
        logic [TERM_W-1:0] term;
        logic              first;
        logic              last;
        logic [I*DW-1:0]   data;
    } issue_st_t;

    issue_st_t st_d, st_q;
    logic      take;

    always_comb begin
        st_d      = st_q;
        vec_ready = !st_q.busy || (st_q.slot == SLOT_W'(SLOTS - 1));
        take      = vec_valid && vec_ready;
        if (st_q.busy) begin
            if (st_q.slot == SLOT_W'(SLOTS - 1)) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
        if (take) begin
            st_d.busy  = 1'b1;
            st_d.slot  = '0;
            st_d.data  = vec_data;
            st_d.first = vec_first;
            st_d.last  = vec_last;
            st_d.term  = vec_first ? '0 : st_q.term + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_data       = st_q.data;
    assign issue_meta.valid = st_q.busy;
    assign issue_meta.first = st_q.first;
    assign issue_meta.last  = st_q.last;
    assign issue_meta.slot  = st_q.slot;
    assign wt_addr          = {st_q.term, st_q.slot};
endmodule

// File: rtl/cmac_lane.sv
module cmac_lane
    import cmac_pkg::*;
#(
    parameter int I     = 4,
    parameter int DW    = 16,
    parameter int ACC_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [I*DW-1:0]   a_vec,
    input  logic [I*DW-1:0]   w_vec,
    input  logic              acc_en,
    input  logic              acc_first,
    input  logic [SLOT_W-1:0] acc_slot,
    output logic [ACC_W-1:0]  res
);
    localparam int PW = 2 * DW;

    logic [DW-1:0]    tap_a [I];
    logic [DW-1:0]    tap_w [I];
    logic [ACC_W-1:0] term_ext [I];

    // Skew: input lane i sees its operand i cycles after issue
    for (genvar i = 0; i < I; i++) begin : g_tap
        if (i == 0) begin : g_direct
            assign tap_a[0] = a_vec[DW-1:0];
            assign tap_w[0] = w_vec[DW-1:0];
        end else begin : g_skew
            logic [DW-1:0] sa_d [i];
            logic [DW-1:0] sa_q [i];
            logic [DW-1:0] sw_d [i];
            logic [DW-1:0] sw_q [i];
            always_comb begin
                sa_d[0] = a_vec[i*DW +: DW];
                sw_d[0] = w_vec[i*DW +: DW];
                for (int k = 1; k < i; k++) begin
                    sa_d[k] = sa_q[k-1];
                    sw_d[k] = sw_q[k-1];
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 0; k < i; k++) begin
                        sa_q[k] <= '0;
                        sw_q[k] <= '0;
                    end
                end else begin
                    sa_q <= sa_d;
                    sw_q <= sw_d;
                end
            end
            assign tap_a[i] = sa_q[i-1];
            assign tap_w[i] = sw_q[i-1];
        end

        logic signed [PW-1:0] prod;
        assign prod        = $signed(tap_a[i]) * $signed(tap_w[i]);
        assign term_ext[i] = {{(ACC_W-PW){prod[PW-1]}}, prod};
    end

    logic [ACC_W-1:0] casc_d [I];
    logic [ACC_W-1:0] casc_q [I];
    logic [ACC_W-1:0] acc_d  [SLOTS];
    logic [ACC_W-1:0] acc_q  [SLOTS];
    logic [ACC_W-1:0] res_d, res_q;
    logic [ACC_W-1:0] base;

    always_comb begin
        casc_d[0] = term_ext[0];
        for (int i = 1; i < I; i++) begin
            casc_d[i] = casc_q[i-1] + term_ext[i];
        end
        acc_d = acc_q;
        res_d = res_q;
        base  = acc_first ? '0 : acc_q[acc_slot];
        if (acc_en) begin
            acc_d[acc_slot] = base + casc_q[I-1];
            res_d           = base + casc_q[I-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < I; i++) casc_q[i] <= '0;
            for (int s = 0; s < SLOTS; s++) acc_q[s] <= '0;
            res_q <= '0;
        end else begin
            casc_q <= casc_d;
            acc_q  <= acc_d;
            res_q  <= res_d;
        end
    end

    assign res = res_q;
endmodule

// File: rtl/cascaded_mac_array.sv
module cascaded_mac_array
    import cmac_pkg::*;
#(
    parameter int I      = 4,
    parameter int O      = 2,
    parameter int DW     = 16,
    parameter int ACC_W  = 48,
    parameter int TERM_W = 11,
    localparam int AW    = TERM_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  logic              vec_first,
    input  logic              vec_last,
    input  logic [I*DW-1:0]   vec_data,
    output logic              vec_ready,
    output logic [AW-1:0]     wt_addr,
    input  logic [O*I*DW-1:0] wt_data,
    output logic              res_valid,
    output logic [SLOT_W-1:0] res_slot,
    output logic [O*ACC_W-1:0] res_data
);
    logic [I*DW-1:0] issue_data;
    cmac_meta_t      issue_meta;
    logic            issue_valid;

    cmac_issue #(.I(I), .DW(DW), .TERM_W(TERM_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_valid  (vec_valid),
        .vec_first  (vec_first),
        .vec_last   (vec_last),
        .vec_data   (vec_data),
        .vec_ready  (vec_ready),
        .issue_data (issue_data),
        .issue_meta (issue_meta),
        .wt_addr    (wt_addr)
    );
    assign issue_valid = issue_meta.valid;

    // Control travels alongside the cascade: I stages
    cmac_meta_t meta_d [I];
    cmac_meta_t meta_q [I];
    cmac_meta_t tail;

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
    } out_st_t;
    out_st_t out_d, out_q;

    always_comb begin
        meta_d[0] = issue_meta;
        for (int k = 1; k < I; k++) meta_d[k] = meta_q[k-1];
        tail        = meta_q[I-1];
        out_d.valid = tail.valid && tail.last;
        out_d.slot  = tail.valid ? tail.slot : out_q.slot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < I; k++) meta_q[k] <= '0;
            out_q <= '0;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    for (genvar o = 0; o < O; o++) begin : g_lane
        cmac_lane #(.I(I), .DW(DW), .ACC_W(ACC_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .a_vec     (issue_data),
            .w_vec     (wt_data[o*I*DW +: I*DW]),
            .acc_en    (tail.valid),
            .acc_first (tail.first),
            .acc_slot  (tail.slot),
            .res       (res_data[o*ACC_W +: ACC_W])
        );
    end

    assign res_valid = out_q.valid;
    assign res_slot  = out_q.slot;
endmodule

// File: rtl/cascaded_mac_array_chk.sv
module cascaded_mac_array_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vec_valid,
    input logic          vec_first,
    input logic          vec_ready,
    input logic          issue_valid,
    input logic [AW-1:0] wt_addr,
    input logic          res_valid,
    input logic [1:0]    res_slot
);
    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && vec_ready |=> !vec_ready);

    // R3
    slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && vec_ready |=> issue_valid && (wt_addr[1:0] == 2'd0));

    // R3
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && (wt_addr[1:0] != 2'd3) |=> issue_valid
            && (wt_addr[1:0] == $past(wt_addr[1:0]) + 2'd1)
            && (wt_addr[AW-1:2] == $past(wt_addr[AW-1:2])));

    // R3
    term_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && vec_ready && vec_first |=> wt_addr[AW-1:2] == '0);

    // R6
    result_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_slot != 2'd3) |=> res_valid && (res_slot == $past(res_slot) + 2'd1));
endmodule

bind cascaded_mac_array cascaded_mac_array_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_valid   (vec_valid),
    .vec_first   (vec_first),
    .vec_ready   (vec_ready),
    .issue_valid (issue_valid),
    .wt_addr     (wt_addr),
    .res_valid   (res_valid),
    .res_slot    (res_slot)
);

// File: tb/cascaded_mac_array_test.sv
module cascaded_mac_array_test;
    localparam int I = 4, O = 2, DW = 16, ACC_W = 48, TERM_W = 11;
    localparam int AW = TERM_W + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vec_valid = 1'b0, vec_first = 1'b0, vec_last = 1'b0;
    logic [I*DW-1:0]    vec_data = '0;
    logic               vec_ready;
    logic [AW-1:0]      wt_addr;
    logic [O*I*DW-1:0]  wt_data;
    logic               res_valid;
    logic [1:0]         res_slot;
    logic [O*ACC_W-1:0] res_data;

    int checks = 0, errors = 0, cyc = 0, ev = 0, last_k = 0;
    int amode = 0, wmode = 0;
    longint exp_v [O][4];
    longint got_v [O][4];
    int     got_cyc [4];

    always #10 clk = ~clk;

    cascaded_mac_array #(.I(I), .O(O), .DW(DW), .ACC_W(ACC_W), .TERM_W(TERM_W)) uut (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_first(vec_first),
        .vec_last(vec_last), .vec_data(vec_data), .vec_ready(vec_ready),
        .wt_addr(wt_addr), .wt_data(wt_data), .res_valid(res_valid),
        .res_slot(res_slot), .res_data(res_data));

    function automatic int wfun(int o, int i, int addr);
        if (wmode == 1) return -32768;
        return ((o*37 + i*11 + addr*5 + 3) % 97) - 48;
    endfunction

    function automatic int afun(int i, int seed);
        if (amode == 1) return -32768;
        if (amode == 2) return 32767;
        return ((i*29 + seed*13 + 7) % 201) - 100;
    endfunction

    always_comb begin
        for (int o = 0; o < O; o++)
            for (int i = 0; i < I; i++)
                wt_data[(o*I+i)*DW +: DW] = DW'(wfun(o, i, int'(wt_addr)));
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (res_valid) begin
            ev = ev + 1;
            got_cyc[res_slot] = cyc;
            for (int o = 0; o < O; o++)
                got_v[o][res_slot] = longint'($signed(res_data[o*ACC_W +: ACC_W]));
        end
    end

    task automatic check(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic send_vec(int term, bit first, bit last, int seed);
        while (!vec_ready) @(negedge clk);
        if (first)
            for (int o = 0; o < O; o++)
                for (int s = 0; s < 4; s++) exp_v[o][s] = 0;
        for (int i = 0; i < I; i++) begin
            vec_data[i*DW +: DW] = DW'(afun(i, seed));
            for (int o = 0; o < O; o++)
                for (int s = 0; s < 4; s++)
                    exp_v[o][s] += longint'(afun(i, seed)) * longint'(wfun(o, i, term*4 + s));
        end
        vec_first = first;
        vec_last  = last;
        vec_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        last_k    = cyc;
        vec_valid = 1'b0;
        for (int s = 0; s < 4; s++) begin
            if (s > 0) @(negedge clk);
            check(int'(wt_addr) == term*4 + s, "R3 weight address", int'(wt_addr), term*4 + s);
            check(vec_ready == (s == 3), "R2 ready pattern", vec_ready, (s == 3));
        end
    endtask

    task automatic run_dot(int nterms, int seed0, int gap);
        int ev0 = ev;
        for (int t = 0; t < nterms; t++) begin
            send_vec(t, t == 0, t == nterms-1, seed0 + t);
            repeat (gap) @(negedge clk);
        end
        repeat (I + 8) @(negedge clk);
        check(ev - ev0 == 4, "R6 four result cycles", ev - ev0, 4);
        for (int s = 0; s < 4; s++) begin
            check(got_cyc[s] == last_k + I + 1 + s, "R7 result latency", got_cyc[s], last_k + I + 1 + s);
            for (int o = 0; o < O; o++)
                check(got_v[o][s] == exp_v[o][s], "R4 dot product", got_v[o][s], exp_v[o][s]);
        end
    endtask

    task automatic test_reset();
        check(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
        check(vec_ready == 1'b1, "R1 vec_ready after reset", vec_ready, 1);
    endtask

    task automatic test_single();
        amode = 0; wmode = 0;
        run_dot(1, 3, 0);
    endtask

    task automatic test_stream_and_gaps();
        longint ref_v [O][4];
        amode = 0; wmode = 0;
        run_dot(9, 11, 0);
        ref_v = got_v;
        run_dot(9, 11, 3);
        for (int o = 0; o < O; o++)
            for (int s = 0; s < 4; s++)
                check(got_v[o][s] == ref_v[o][s], "R9 idle gaps", got_v[o][s], ref_v[o][s]);
    endtask

    task automatic test_first_clears();
        int ev0;
        amode = 0; wmode = 0;
        ev0 = ev;
        send_vec(0, 1'b1, 1'b0, 50);
        send_vec(1, 1'b0, 1'b0, 51);
        send_vec(2, 1'b0, 1'b0, 52);
        repeat (I + 8) @(negedge clk);
        check(ev == ev0, "R6 no result without end flag", ev - ev0, 0);
        // R5: new start vector must discard the partial sums above
        run_dot(3, 70, 1);
    endtask

    task automatic test_extremes();
        wmode = 1;
        amode = 1;
        run_dot(20, 0, 0);
        check(got_v[0][0] == 64'sd85899345920, "R8 positive extreme", got_v[0][0], 64'sd85899345920);
        amode = 2;
        run_dot(20, 0, 0);
        check(got_v[O-1][3] == -64'sd85896724480, "R8 negative extreme", got_v[O-1][3], -64'sd85896724480);
        amode = 0; wmode = 0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_single();
        test_stream_and_gaps();
        test_first_clears();
        test_extremes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule